// File: doc/BRIEF.md
# Null-Terminated String Compare Engine

This block compares two byte strings held in memory and reports how they relate. One string is the master and must end in a zero byte. The other is the test string and needs no terminator. On a start pulse the engine latches the two base addresses. It then walks both strings through one shared byte-wide read port, fetching the master byte and then the test byte at each offset, and stops as soon as the result is known.

The result comes back as two flags and a one-cycle done pulse. The zero flag marks an exact match up to and including the master's terminator. The carry flag marks a partial match, where the test string ended first and so is a prefix of the master. Both flags clear means the strings differ.

An upper address bound is supplied as an input. Any read that would land above it aborts the compare, and the engine then reports both flags clear. This covers strings that run off the end of memory, including an address sum that would carry past the top of the address space.

Top module: `strcmp_engine`

## Requirements
- R1: A start pulse is accepted only while the engine is idle. On acceptance the base addresses are latched and both flags read 0 from the next cycle. A start pulse during a compare is ignored, and the result still reflects the original bases.
- R2: Reads go out in the order master at master_base+k, then test at test_base+k, for k = 0, 1, 2, and so on. Only one read is outstanding at a time, and rd_req stays high with rd_addr stable until the cycle in which rd_valid is seen with it.
- R3: If both strings are equal at every offset up to the first zero byte of the master, and the test byte at that offset is also zero, the result is flag_z=1 and flag_c=0.
- R4: If the test byte is zero at an offset where the master byte is non-zero, and all earlier pairs were equal, the result is flag_z=0 and flag_c=1.
- R5: If the two bytes differ at an offset before either terminator, the result is flag_z=0 and flag_c=0. The same result applies when the master byte is zero and the test byte at that offset is non-zero.
- R6: No byte beyond the deciding offset is fetched. An unterminated test string is read no further than the master's terminator.
- R7: A read address is formed from base+offset without wrap-around. If that address exceeds mem_top, no request is issued for it, and the compare ends with flag_z=0 and flag_c=0. mem_top must be held steady during a compare.
- R8: done is a one-cycle pulse. The flags hold their value from the done cycle until the next accepted start.
- R9: After reset, done, flag_z, flag_c and rd_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compare (sampled only while idle) |
| master_base | input | AW | Address of the first master byte |
| test_base | input | AW | Address of the first test byte |
| mem_top | input | AW | Highest address that may be read |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | AW | Byte address of the pending read |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle completion pulse |
| flag_z | output | 1 | Exact match |
| flag_c | output | 1 | Test string is a proper prefix of the master |

## Verification
A verdict reached from a read is registered at the clock edge where the deciding test byte is accepted, so done and the flags are due one cycle after that handshake. An abort for an out-of-range address is detected in the state after the last handshake (or after start), so its done is due two cycles after that event. The bench notes the cycle of every start and every read handshake it serves, and compares the cycle in which done appears against these offsets. Flags are sampled at the done cycle and again one cycle later, and read addresses are checked at each handshake against the expected alternating sequence.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASTER,
        ST_TEST
    } phase_e;

    typedef enum logic [1:0] {
        VD_CONTINUE,
        VD_EXACT,
        VD_PREFIX,
        VD_DIFFER
    } verdict_e;

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

    function automatic verdict_e judge_pair(char_t m, char_t t);
        verdict_e v;
        if (m == '0)
            v = (t == '0) ? VD_EXACT : VD_DIFFER;
        else if (t == '0)
            v = VD_PREFIX;
        else if (t != m)
            v = VD_DIFFER;
        else
            v = VD_CONTINUE;
        return v;
    endfunction

    function automatic flags_t verdict_flags(verdict_e v);
        flags_t f;
        f.z = (v == VD_EXACT);
        f.c = (v == VD_PREFIX);
        return f;
    endfunction

endpackage

// File: rtl/strcmp_judge.sv
module strcmp_judge
    import strcmp_pkg::*;
(
    input  char_t    m_byte,
    input  char_t    t_byte,
    output verdict_e verdict,
    output flags_t   flags
);

    always_comb begin
        verdict = judge_pair(m_byte, t_byte);
        flags   = verdict_flags(verdict);
    end

endmodule

// File: rtl/strcmp_walker.sv
module strcmp_walker #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic          sel_test,
    input  logic [AW-1:0] m_base,
    input  logic [AW-1:0] t_base,
    input  logic [AW-1:0] mem_top,
    output logic [AW-1:0] rd_addr,
    output logic          in_range
);

    localparam int OW = AW + 1;
    localparam int SW = AW + 2;

    logic [AW-1:0] m_q, t_q;
    logic [OW-1:0] off_q;
    logic [SW-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q   <= '0;
            t_q   <= '0;
            off_q <= '0;
        end else if (load) begin
            m_q   <= m_base;
            t_q   <= t_base;
            off_q <= '0;
        end else if (advance) begin
            off_q <= off_q + 1'b1;
        end
    end

    always_comb begin
        sum      = {2'b00, (sel_test ? t_q : m_q)} + {1'b0, off_q};
        rd_addr  = sum[AW-1:0];
        in_range = (sum <= {2'b00, mem_top});
    end

endmodule

// File: rtl/strcmp_seq.sv
module strcmp_seq
    import strcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     in_range,
    input  logic     rd_valid,
    input  verdict_e verdict,
    output logic     rd_req,
    output logic     sel_test,
    output logic     load,
    output logic     advance,
    output logic     capture_m,
    output logic     finish,
    output logic     aborted,
    output logic     busy
);

    phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        rd_req    = 1'b0;
        sel_test  = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        capture_m = 1'b0;
        finish    = 1'b0;
        aborted   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_MASTER;
                end
            end
            ST_MASTER: begin
                if (!in_range) begin
                    finish  = 1'b1;
                    aborted = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    rd_req = 1'b1;
                    if (rd_valid) begin
                        capture_m = 1'b1;
                        state_d   = ST_TEST;
                    end
                end
            end
            ST_TEST: begin
                sel_test = 1'b1;
                if (!in_range) begin
                    finish  = 1'b1;
                    aborted = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    rd_req = 1'b1;
                    if (rd_valid) begin
                        if (verdict == VD_CONTINUE) begin
                            advance = 1'b1;
                            state_d = ST_MASTER;
                        end else begin
                            finish  = 1'b1;
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/strcmp_engine.sv
module strcmp_engine
    import strcmp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] master_base,
    input  logic [AW-1:0] test_base,
    input  logic [AW-1:0] mem_top,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic [7:0]    rd_data,
    output logic          done,
    output logic          flag_z,
    output logic          flag_c
);

    logic     load, advance, sel_test, capture_m, finish, aborted, busy;
    logic     in_range;
    verdict_e verdict;
    flags_t   pair_flags;
    flags_t   flags_q;
    char_t    m_byte_q;
    logic     done_q;

    strcmp_walker #(.AW(AW)) u_walker (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (advance),
        .sel_test (sel_test),
        .m_base   (master_base),
        .t_base   (test_base),
        .mem_top  (mem_top),
        .rd_addr  (rd_addr),
        .in_range (in_range)
    );

    strcmp_judge u_judge (
        .m_byte  (m_byte_q),
        .t_byte  (rd_data),
        .verdict (verdict),
        .flags   (pair_flags)
    );

    strcmp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_range  (in_range),
        .rd_valid  (rd_valid),
        .verdict   (verdict),
        .rd_req    (rd_req),
        .sel_test  (sel_test),
        .load      (load),
        .advance   (advance),
        .capture_m (capture_m),
        .finish    (finish),
        .aborted   (aborted),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            flags_q  <= '0;
            m_byte_q <= '0;
        end else begin
            done_q <= finish;
            if (load)
                flags_q <= '0;
            else if (finish)
                flags_q <= aborted ? '0 : pair_flags;
            if (capture_m)
                m_byte_q <= rd_data;
        end
    end

    assign done   = done_q;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;

endmodule

// File: rtl/strcmp_engine_chk.sv
module strcmp_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_valid,
    input logic [AW-1:0] mem_top,
    input logic          done,
    input logic          flag_z,
    input logic          flag_c
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(flag_z && flag_c));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R7
    addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr <= mem_top));

    // R1
    flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !flag_z && !flag_c));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(flag_z) && $stable(flag_c)));

endmodule

bind strcmp_engine strcmp_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .mem_top  (mem_top),
    .done     (done),
    .flag_z   (flag_z),
    .flag_c   (flag_c)
);

// File: tb/tb_strcmp_engine.sv
`timescale 1ns/1ps
module tb_strcmp_engine;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] master_base = '0;
    logic [AW-1:0] test_base = '0;
    logic [AW-1:0] mem_top = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          done, flag_z, flag_c;

    strcmp_engine #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .master_base(master_base), .test_base(test_base), .mem_top(mem_top),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .flag_z(flag_z), .flag_c(flag_c)
    );

    always #2.5 clk = ~clk;

    logic [7:0] mem [256];
    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int last_event = 0;
    int wait_cnt = 0;
    int cur_m = 0, cur_t = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory responder: random latency 0..2 cycles; address order checked (R2, R7)
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_valid = 1'b0;
        end else if (!rst && rd_req) begin
            if (wait_cnt == 0) begin
                int exp_a;
                exp_a = ((rd_cnt % 2) == 0) ? cur_m + rd_cnt / 2 : cur_t + rd_cnt / 2;
                check(int'(rd_addr) == exp_a, "R2", "read address order",
                      int'(rd_addr), exp_a);
                check(int'(rd_addr) <= int'(mem_top), "R7", "read within top",
                      int'(rd_addr), int'(mem_top));
                rd_data  = mem[rd_addr[7:0]];
                rd_valid = 1'b1;
                rd_cnt++;
                last_event = cyc;
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt--;
            end
        end
    end

    // Reference model built from the requirements
    task automatic ref_cmp(input int mb, input int tb, input int top,
                           output bit ez, output bit ec, output bit eab,
                           output int nreads);
        logic [7:0] mch, tch;
        ez = 0; ec = 0; eab = 0; nreads = 0;
        for (int k = 0; k < 70000; k++) begin
            if (mb + k > top) begin eab = 1; return; end
            mch = mem[(mb + k) % 256];
            nreads++;
            if (tb + k > top) begin eab = 1; return; end
            tch = mem[(tb + k) % 256];
            nreads++;
            if (mch == 8'h00) begin ez = (tch == 8'h00); return; end
            if (tch == 8'h00) begin ec = 1; return; end
            if (tch != mch) return;
        end
    endtask

    task automatic run_cmp(input int mb, input int tb, input int top, input bit poke);
        bit ez, ec, eab;
        int en, n, due, sz, sc;
        string tag;
        ref_cmp(mb, tb, top, ez, ec, eab, en);
        tag = eab ? "R7" : (ez ? "R3" : (ec ? "R4" : "R5"));
        @(negedge clk);
        master_base = AW'(mb); test_base = AW'(tb); mem_top = AW'(top);
        rd_cnt = 0; cur_m = mb; cur_t = tb; last_event = cyc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!flag_z && !flag_c, "R1", "flags cleared after start",
              {flag_z, flag_c}, 0);
        if (poke && !done) begin
            @(negedge clk);
            if (!done) begin
                master_base = AW'(tb); test_base = AW'(mb);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        check(done, tag, "done seen", done, 1);
        due = last_event + (eab ? 2 : 1);
        check(cyc == due, "R8", "done cycle", cyc, due);
        check(flag_z == ez, tag, "flag_z", flag_z, ez);
        check(flag_c == ec, tag, "flag_c", flag_c, ec);
        check(rd_cnt == en, "R6", "read count", rd_cnt, en);
        sz = flag_z; sc = flag_c;
        @(negedge clk);
        check(!done, "R8", "done single cycle", done, 0);
        repeat (2) @(negedge clk);
        check(flag_z == sz && flag_c == sc, "R8", "flags held",
              {flag_z, flag_c}, {sz[0], sc[0]});
    endtask

    task automatic put_str(input int a, input string s, input bit term);
        for (int i = 0; i < s.len(); i++) mem[(a + i) % 256] = s[i];
        if (term) mem[(a + s.len()) % 256] = 8'h00;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) mem[i] = 8'h2e;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!done && !flag_z && !flag_c && !rd_req, "R9", "reset outputs",
              {done, flag_z, flag_c, rd_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !rd_req, "R9", "idle after reset", {done, rd_req}, 0);

        // Directed corners
        put_str(8'h10, "abc", 1); put_str(8'h30, "abc", 1);
        run_cmp(8'h10, 8'h30, 8'hff, 0);          // R3 exact
        put_str(8'h30, "ab", 1);
        run_cmp(8'h10, 8'h30, 8'hff, 0);          // R4 prefix
        put_str(8'h30, "x", 1);
        run_cmp(8'h10, 8'h30, 8'hff, 0);          // R5 first byte differs
        put_str(8'h30, "abcd", 0);
        run_cmp(8'h10, 8'h30, 8'hff, 0);          // R5/R6 master ends, test goes on
        mem[8'h50] = 8'h00; mem[8'h60] = 8'h00;
        run_cmp(8'h50, 8'h60, 8'hff, 0);          // R3 both empty
        mem[8'h60] = "k";
        run_cmp(8'h50, 8'h60, 8'hff, 0);          // R5 empty master, test non-null
        run_cmp(8'h90, 8'h10, 8'h80, 0);          // R7 master base above top
        put_str(8'h3e, "ab", 0);
        run_cmp(8'h10, 8'h3e, 8'h3f, 0);          // R7 test runs past top
        mem[8'hff] = "q";
        run_cmp(16'hffff, 16'hffff, 16'hffff, 0); // R7 no wrap past address space
        put_str(8'h70, "longerstring", 1); put_str(8'ha0, "longerstring", 1);
        run_cmp(8'h70, 8'ha0, 8'hff, 1);          // R1 start while busy ignored

        // Constrained random
        for (int t = 0; t < 60; t++) begin
            int mb, tb, top, len, mode, p;
            top  = 100 + $urandom % 156;
            mb   = $urandom % 256;
            tb   = $urandom % 256;
            len  = $urandom % 10;
            mode = $urandom % 4;
            for (int j = 0; j < len; j++) begin
                logic [7:0] ch;
                ch = 8'h61 + 8'($urandom % 4);
                mem[(mb + j) % 256] = ch;
                mem[(tb + j) % 256] = ch;
            end
            mem[(mb + len) % 256] = 8'h00;
            p = $urandom % (len + 1);
            case (mode)
                0: mem[(tb + len) % 256] = 8'h00;
                1: mem[(tb + p) % 256] = 8'h00;
                2: mem[(tb + p) % 256] = 8'h7a;
                default: mem[(tb + len) % 256] = 8'h79;
            endcase
            run_cmp(mb, tb, top, t % 7 == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule